// File: doc/BRIEF.md
# Multi-Channel FIFO Event Interrupt Aggregator

This block gathers single-cycle event pulses from up to ten audio channel FIFOs and turns them into sticky status bits and one interrupt line. Each channel has six event types: almost-empty, almost-full and overflow, each for both the capture side and the playback side. Software reads the sticky bits through a simple register bus and clears them by writing ones. A per-event enable selects which sticky bits show up in the masked view. A separate per-channel interrupt enable decides which channels may drive the shared interrupt output.

Every channel owns one 8-bit lane, and four lanes share one 32-bit register. Channel c therefore sits in register c/4 at bit offset 8*(c%4), so ten channels need three registers per register group. Inside a lane, bits 0 to 5 carry the six events, and bits 6 and 7 are reserved.

Top module: `mchan_evt_irq`

## Requirements
- R1: An event pulse on input bit c*6+e, with e in 0..5 (0 capture almost-empty, 1 capture almost-full, 2 playback almost-empty, 3 playback almost-full, 4 capture overflow, 5 playback overflow), sets raw status bit 8*(c%4)+e of the raw register for group c/4. The set is visible on the clock edge that samples the pulse.
- R2: A raw bit stays set until a write to the matching clear register puts a 1 at its position. Writing 0, or writing to another lane, leaves it unchanged. Clear registers read as zero.
- R3: When an event pulse and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R4: The masked register for a group equals its raw register AND its enable register, bit by bit.
- R5: `irq` is high exactly when some channel has its interrupt-enable bit set and at least one masked event bit set.
- R6: In every lane of the enable, clear, raw and masked registers, bits 6 and 7 ignore writes and read as zero.
- R7: After reset, all registers read zero and `irq` is low.
- R8: Bits of lanes with no channel (register group 2, bits 16..31) and bits 10..31 of the interrupt-enable register read as zero.
- R9: Word addresses are as follows: 0..2 hold the enables, 3..5 the clears, 6..8 the raw status, 9..11 the masked status, and 12 the per-channel interrupt enable. Writes take effect on the clock edge when `bus_wr` is high. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 60 | Event pulses, six per channel, channel c at bits 6c..6c+5 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Aggregated interrupt |

## Verification
An event pulse and a write-one-to-clear aimed at the same raw bit can land in the same clock cycle. The bench provokes this by driving the pulse and the clear write on the same falling edge and releasing both one cycle later. It then reads the raw register and expects the bit set. A neighbouring bit in the same clear write, with no pulse of its own, must read back cleared.

// File: rtl/mchan_evt_irq.sv
module mchan_evt_irq #(
  parameter int NUM_CH = 10,
  parameter int EVT_W  = 6,
  parameter int LANE_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH*EVT_W-1:0] evt_i,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    irq
);
  localparam int LANES    = DATA_W / LANE_W;
  localparam int NUM_REG  = (NUM_CH + LANES - 1) / LANES;
  localparam int ENA_BASE = 0;
  localparam int CLR_BASE = NUM_REG;
  localparam int RAW_BASE = 2 * NUM_REG;
  localparam int MSK_BASE = 3 * NUM_REG;
  localparam int PEN_ADDR = 4 * NUM_REG;

  logic [NUM_CH-1:0][EVT_W-1:0] raw_q, en_q, msk;
  logic [NUM_CH-1:0]            pen_q, ch_irq;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int R   = c / LANES;
    localparam int OFF = (c % LANES) * LANE_W;
    wire en_hit  = bus_wr && (bus_addr == ADDR_W'(ENA_BASE + R));
    wire clr_hit = bus_wr && (bus_addr == ADDR_W'(CLR_BASE + R));
    wire [EVT_W-1:0] clr_bits = clr_hit ? bus_wdata[OFF +: EVT_W] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q[c] <= '0;
        en_q[c]  <= '0;
      end else begin
        raw_q[c] <= (raw_q[c] & ~clr_bits) | evt_i[c*EVT_W +: EVT_W];
        if (en_hit) en_q[c] <= bus_wdata[OFF +: EVT_W];
      end
    end

    assign msk[c]    = raw_q[c] & en_q[c];
    assign ch_irq[c] = pen_q[c] && (|msk[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pen_q <= '0;
    else if (bus_wr && bus_addr == ADDR_W'(PEN_ADDR))
      pen_q <= bus_wdata[NUM_CH-1:0];
  end

  assign irq = |ch_irq;

  logic [NUM_REG-1:0][DATA_W-1:0] en_v, raw_v, msk_v;

  always_comb begin
    en_v  = '0;
    raw_v = '0;
    msk_v = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      en_v[c / LANES][(c % LANES) * LANE_W +: EVT_W]  = en_q[c];
      raw_v[c / LANES][(c % LANES) * LANE_W +: EVT_W] = raw_q[c];
      msk_v[c / LANES][(c % LANES) * LANE_W +: EVT_W] = msk[c];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int r = 0; r < NUM_REG; r++) begin
      if (bus_addr == ADDR_W'(ENA_BASE + r)) bus_rdata = en_v[r];
      if (bus_addr == ADDR_W'(RAW_BASE + r)) bus_rdata = raw_v[r];
      if (bus_addr == ADDR_W'(MSK_BASE + r)) bus_rdata = msk_v[r];
    end
    if (bus_addr == ADDR_W'(PEN_ADDR)) bus_rdata = DATA_W'(pen_q);
  end
endmodule

// File: rtl/mchan_evt_irq_chk.sv
module mchan_evt_irq_chk #(
  parameter int NUM_CH = 10,
  parameter int EVT_W  = 6,
  parameter int LANE_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH*EVT_W-1:0] evt_i,
  input logic                    bus_wr,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [DATA_W-1:0]       bus_wdata,
  input logic [DATA_W-1:0]       bus_rdata,
  input logic                    irq,
  input logic [NUM_CH*EVT_W-1:0] raw_q
);
  localparam int LANES    = DATA_W / LANE_W;
  localparam int NUM_REG  = (NUM_CH + LANES - 1) / LANES;
  localparam int CLR_BASE = NUM_REG;
  localparam int PEN_ADDR = 4 * NUM_REG;

  function automatic logic [DATA_W-1:0] rsv_mask();
    logic [DATA_W-1:0] m = '0;
    for (int l = 0; l < LANES; l++)
      for (int b = EVT_W; b < LANE_W; b++) m[l*LANE_W + b] = 1'b1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] RSV = rsv_mask();

  for (genvar b = 0; b < NUM_CH*EVT_W; b++) begin : g_bit
    localparam int CH  = b / EVT_W;
    localparam int R   = CH / LANES;
    localparam int POS = (CH % LANES) * LANE_W + (b % EVT_W);
    wire clr_b = bus_wr && bus_addr == ADDR_W'(CLR_BASE + R) && bus_wdata[POS];

    assert_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[b] |=> raw_q[b]);
    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_b && !evt_i[b]) |=> !raw_q[b]);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q[b] && !clr_b) |=> raw_q[b]);
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_b && evt_i[b]) |=> raw_q[b]);
  end

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|raw_q));
  assert_rsv_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < ADDR_W'(PEN_ADDR)) |-> ((bus_rdata & RSV) == '0));
endmodule

bind mchan_evt_irq mchan_evt_irq_chk #(
  .NUM_CH(NUM_CH), .EVT_W(EVT_W), .LANE_W(LANE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .raw_q(raw_q)
);

// File: tb/sim_mchan_evt_irq.sv
module sim_mchan_evt_irq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 10;
  localparam int EW  = 6;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NCH*EW-1:0] evt = '0;
  logic          wr = 0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  int checks = 0;
  int errors = 0;

  // channel, event, raw address, bit position
  localparam int NVEC = 10;
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 6, 0},  '{1, 1, 6, 9},  '{2, 2, 6, 18}, '{3, 5, 6, 29},
    '{4, 3, 7, 3},  '{5, 4, 7, 12}, '{6, 1, 7, 17}, '{7, 0, 7, 24},
    '{8, 5, 8, 5},  '{9, 2, 8, 10}
  };

  mchan_evt_irq u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0; wdata = '0;
  endtask

  task automatic read_check(string req, logic [3:0] a, logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic pulse(int ch, int e);
    @(negedge clk);
    evt = '0;
    evt[ch*EW + e] = 1'b1;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 reset state
    for (int a = 0; a <= 12; a++) read_check("R7 reset reg", 4'(a), 32'h0);
    check("R7 reset irq", {31'b0, irq}, 32'h0);

    // R1 / R9 mapping table, R2 clear
    for (int i = 0; i < NVEC; i++) begin
      pulse(VEC[i][0], VEC[i][1]);
      read_check("R1 lane mapping", 4'(VEC[i][2]), 32'h1 << VEC[i][3]);
      write(4'(VEC[i][2] - 3), 32'h1 << VEC[i][3]);
      read_check("R2 clear by write-one", 4'(VEC[i][2]), 32'h0);
    end

    // R2 hold, zero-write, other lane
    pulse(4, 2);
    repeat (4) @(negedge clk);
    read_check("R2 hold", 4'd7, 32'h0000_0004);
    write(4'd4, 32'h0000_0000);
    read_check("R2 zero write", 4'd7, 32'h0000_0004);
    write(4'd4, 32'hFFFF_FF00);
    read_check("R2 other lane write", 4'd7, 32'h0000_0004);
    read_check("R2 clear reads zero", 4'd4, 32'h0);

    // R3 set wins over clear; neighbour bit cleared
    @(negedge clk);
    wr = 1; addr = 4'd4; wdata = 32'h0000_0006;
    evt = '0; evt[4*EW + 1] = 1'b1;
    @(negedge clk);
    wr = 0; wdata = '0; evt = '0;
    read_check("R3 set wins", 4'd7, 32'h0000_0002);
    write(4'd4, 32'h0000_0002);

    // R6 / R8 reserved bits
    write(4'd0, 32'hFFFF_FFFF);
    read_check("R6 enable reserved bits", 4'd0, 32'h3F3F_3F3F);
    write(4'd2, 32'hFFFF_FFFF);
    read_check("R8 missing lanes", 4'd2, 32'h0000_3F3F);
    write(4'd12, 32'hFFFF_FFFF);
    read_check("R8 interrupt enable width", 4'd12, 32'h0000_03FF);
    write(4'd12, 32'h0);
    write(4'd2, 32'h0);

    // R4 masked view
    write(4'd0, 32'h0000_0200);
    pulse(1, 1);
    pulse(0, 0);
    read_check("R4 raw", 4'd6, 32'h0000_0201);
    read_check("R4 masked", 4'd9, 32'h0000_0200);
    check("R5 irq off without channel enable", {31'b0, irq}, 32'h0);

    // R5 interrupt gating
    write(4'd12, 32'h0000_0001);
    check("R5 enabled channel with no masked bit", {31'b0, irq}, 32'h0);
    write(4'd12, 32'h0000_0002);
    check("R5 irq raised", {31'b0, irq}, 32'h1);
    write(4'd3, 32'h0000_0200);
    check("R5 irq dropped after clear", {31'b0, irq}, 32'h0);
    pulse(1, 1);
    check("R5 irq re-raised", {31'b0, irq}, 32'h1);
    write(4'd0, 32'h0);
    read_check("R4 masked after enable off", 4'd9, 32'h0);
    check("R5 irq off after mask", {31'b0, irq}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule